// File: doc/BRIEF.md
# Synchronous Serial Controller with Programmable Bit Rate

This block moves one 8-bit or 16-bit word at a time over a four-wire synchronous serial link. It sends and receives together: while a word leaves on the data output, the word coming back is assembled from the data input. As master it makes the serial clock from the system clock, with a 16-bit divisor, and pulls one of seven select lines low for the length of the word. As slave it follows an external serial clock and starts a word when its select input goes low.

Each word carries its own settings. The host presents the word and the settings, then pulses `start`. The block reports `busy` while the transfer runs. It pulses `done` once with the received word on `rx_word`. Clock polarity and clock phase can be set for each word. A host can therefore talk to several peripherals with different conventions on the same pins.

Top module: `spi_ctrl`

## Requirements
- R1: In master mode each half period of `sck_o` lasts exactly B system clock cycles, where B is the effective divisor. The first edge of `sck_o` comes B cycles after the cycle that accepted `start`.
- R2: A `cfg_baud` value of 0 or 1 acts as a divisor of 2. Any value from 2 to 65535 is used as it is.
- R3: `sck_o` idles at `cfg_cpol`. A master word makes exactly two edges per bit, so the line is back at its idle level afterwards.
- R4: Data goes out most significant bit first. With `cfg_cpha`=0 the input is sampled on the first (leading) edge of each bit, and the output changes on the trailing edge. With `cfg_cpha`=1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R5: With `cfg_wide`=1 a word is 16 bits. With `cfg_wide`=0 a word is 8 bits: only `tx_word[7:0]` is sent, and `rx_word[15:8]` reads zero.
- R6: A `cfg_sel` value k from 1 to 7 drives `cs_n_o[k-1]` low, from the cycle after `start` is accepted until B cycles after the last clock edge. The other select lines stay high. A `cfg_sel` of 0 selects no line, but the word is still clocked. At most one select line is low at any time.
- R7: When `done` is high, `rx_word` holds the bits sampled on `miso_i`, most significant bit first.
- R8: `done` is high for exactly one cycle per word. In master mode it rises in the same cycle in which `busy` falls and the select line is released.
- R9: A `start` while `busy` is high is ignored. The settings and `tx_word` are taken in the cycle that accepts `start`, and later changes do not affect the word in progress.
- R10: In slave mode (`cfg_master`=0) a falling `ss_n_i` loads `tx_word` and the current settings. The word then goes out on `miso_o` in step with `sck_i`, following the R4 edge rules, while the word on `mosi_i` is collected. `done` pulses once the last bit has been sampled. The inputs pass through a two-stage synchronizer.
- R11: `miso_o` is low whenever the slave is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| cfg_baud | input | 16 | Half-period divisor B |
| cfg_sel | input | 3 | Select line number 1..7, 0 = none |
| start | input | 1 | Begin a master word |
| tx_word | input | 16 | Word to send |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle word-complete pulse |
| rx_word | output | 16 | Received word |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| cs_n_o | output | 7 | Master select lines, active low |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |

## Verification
The bench aims at the divisor clamp. A design that used 0 or 1 literally would toggle the clock every cycle, or never. It compares each output pin against a behavioural model on every clock, in all four polarity and phase combinations. Shifting on the first leading edge in phase-1 mode, or on the final trailing edge in phase-0 mode, shows up there as a lost or repeated bit. The bench issues a second `start` in mid-word and changes the divisor and select line at the same time, to catch a design that restarts or re-reads its settings. It also runs 8-bit words whose upper data bits are nonzero, to catch leakage into the narrow word.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int WORD_W   = 16;
    localparam int NARROW_W = 8;
    localparam int BAUD_W   = 16;
    localparam int SEL_W    = 3;
    localparam int CS_N     = 7;
    localparam int EDGE_W   = $clog2(2 * WORD_W + 1);

    typedef struct packed {
        logic              master;
        logic              cpol;
        logic              cpha;
        logic              wide;
        logic [BAUD_W-1:0] baud;
        logic [SEL_W-1:0]  sel;
    } spi_cfg_t;

    function automatic logic [BAUD_W-1:0] eff_baud(input logic [BAUD_W-1:0] b);
        return (b < BAUD_W'(2)) ? BAUD_W'(2) : b;
    endfunction

    function automatic logic [EDGE_W-1:0] edge_total(input logic wide);
        return wide ? EDGE_W'(2 * WORD_W) : EDGE_W'(2 * NARROW_W);
    endfunction
endpackage

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = !clr && (cnt_q == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         wide,
    input  logic         sample_ev,
    input  logic         change_ev,
    input  logic         sdi,
    output logic         sdo,
    output logic [W-1:0] rx_q,
    output logic         last_sample
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     tx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_bits;

    assign n_bits      = wide ? CNT_W'(W) : CNT_W'(NW);
    assign sdo         = tx_q[W-1];
    assign last_sample = sample_ev && (cnt_q == n_bits - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            tx_q  <= wide ? load_word : {load_word[NW-1:0], {(W-NW){1'b0}}};
            rx_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (sample_ev && cnt_q < n_bits) begin
                rx_q  <= {rx_q[W-2:0], sdi};
                cnt_q <= cnt_q + 1'b1;
            end
            if (change_ev && cnt_q != '0 && cnt_q < n_bits)
                tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front (
    input  logic clk,
    input  logic rst,
    input  logic cpol,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic mosi_i,
    output logic sel,
    output logic ss_fall,
    output logic lead,
    output logic trail,
    output logic mosi_s
);
    logic [2:0] sck_p;
    logic [1:0] ss_p;
    logic       ss_prev;
    logic [1:0] mo_p;
    logic       sck_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p   <= '0;
            ss_p    <= 2'b11;
            ss_prev <= 1'b1;
            mo_p    <= '0;
        end else begin
            sck_p   <= {sck_p[1:0], sck_i};
            ss_p    <= {ss_p[0], ss_n_i};
            ss_prev <= ss_p[1];
            mo_p    <= {mo_p[0], mosi_i};
        end
    end

    assign sel      = !ss_p[1];
    assign ss_fall  = ss_prev && !ss_p[1];
    assign sck_edge = sck_p[2] ^ sck_p[1];
    assign lead     = sel && sck_edge && (sck_p[1] != cpol);
    assign trail    = sel && sck_edge && (sck_p[1] == cpol);
    assign mosi_s   = mo_p[1];
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sck_o,
    output logic              mosi_o,
    output logic [CS_N-1:0]   cs_n_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o
);
    spi_cfg_t          cfg_q;
    spi_cfg_t          cfg_d;
    logic              run_q;
    logic              sck_q;
    logic [EDGE_W-1:0] edge_q;
    logic              done_q;
    logic              tick;
    logic              accept;
    logic              s_load;
    logic              at_end;
    logic              m_edge;
    logic              m_lead;
    logic              m_trail;
    logic              s_sel;
    logic              s_fall;
    logic              s_lead;
    logic              s_trail;
    logic              s_mosi;
    logic              ev_lead;
    logic              ev_trail;
    logic              core_sdo;
    logic              core_last;
    logic [WORD_W-1:0] core_rx;
    logic              slave_act;

    assign cfg_d = '{master: cfg_master, cpol: cfg_cpol, cpha: cfg_cpha,
                     wide: cfg_wide, baud: cfg_baud, sel: cfg_sel};

    assign accept = cfg_master && start && !run_q;
    assign s_load = !cfg_master && s_fall && !run_q;

    spi_baud_div #(.CNT_W(BAUD_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (!run_q),
        .half (eff_baud(cfg_q.baud)),
        .tick (tick)
    );

    spi_slave_front u_front (
        .clk     (clk),
        .rst     (rst),
        .cpol    (cfg_q.cpol),
        .sck_i   (sck_i),
        .ss_n_i  (ss_n_i),
        .mosi_i  (mosi_i),
        .sel     (s_sel),
        .ss_fall (s_fall),
        .lead    (s_lead),
        .trail   (s_trail),
        .mosi_s  (s_mosi)
    );

    assign at_end    = tick && (edge_q == edge_total(cfg_q.wide));
    assign m_edge    = tick && (edge_q != edge_total(cfg_q.wide));
    assign m_lead    = m_edge && !edge_q[0];
    assign m_trail   = m_edge && edge_q[0];
    assign slave_act = !cfg_q.master && s_sel;
    assign ev_lead   = m_lead  || (s_lead  && !cfg_q.master);
    assign ev_trail  = m_trail || (s_trail && !cfg_q.master);

    spi_shift_core #(.W(WORD_W), .NW(NARROW_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .load        (accept || s_load),
        .load_word   (tx_word),
        .wide        ((accept || s_load) ? cfg_wide : cfg_q.wide),
        .sample_ev   (cfg_q.cpha ? ev_trail : ev_lead),
        .change_ev   (cfg_q.cpha ? ev_lead : ev_trail),
        .sdi         (cfg_q.master ? miso_i : s_mosi),
        .sdo         (core_sdo),
        .rx_q        (core_rx),
        .last_sample (core_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            run_q  <= 1'b0;
            sck_q  <= 1'b0;
            edge_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= at_end || (core_last && !cfg_q.master);
            if (accept || s_load) cfg_q <= cfg_d;
            if (accept) begin
                run_q  <= 1'b1;
                sck_q  <= cfg_cpol;
                edge_q <= '0;
            end else if (at_end) begin
                run_q  <= 1'b0;
            end else if (m_edge) begin
                sck_q  <= ~sck_q;
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign cs_n_o[g] = !(run_q && (cfg_q.sel == SEL_W'(g + 1)));
    end

    assign busy    = run_q || slave_act;
    assign done    = done_q;
    assign sck_o   = run_q ? sck_q : cfg_cpol;
    assign mosi_o  = run_q ? core_sdo : 1'b0;
    assign miso_o  = slave_act ? core_sdo : 1'b0;
    assign rx_word = cfg_q.wide ? core_rx
                                : {{(WORD_W-NARROW_W){1'b0}}, core_rx[NARROW_W-1:0]};
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       run_q,
    input logic       sck_o,
    input logic [6:0] cs_n_o
);
    a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n_o));

    a_r6_select_needs_busy: assert property (@(posedge clk) disable iff (rst)
        (|(~cs_n_o)) |-> busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_release: assert property (@(posedge clk) disable iff (rst)
        done |-> !run_q);

    a_r9_select_held: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(cs_n_o));

    a_r1_half_period_min: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$stable(sck_o)) |=> $stable(sck_o));
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .run_q  (run_q),
    .sck_o  (sck_o),
    .cs_n_o (cs_n_o)
);

// File: tb/spi_ctrl_tb_top.sv
module spi_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b0;
    logic [15:0] cfg_baud = 16'd2;
    logic [2:0]  cfg_sel = 3'd0;
    logic        start = 1'b0;
    logic [15:0] tx_word = 16'h0;
    logic        busy, done, sck_o, mosi_o, miso_o;
    logic [15:0] rx_word;
    logic [6:0]  cs_n_o;
    logic        miso_i = 1'b0, sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int done_seen = 0;
    logic [15:0] done_rx = 16'h0;

    always #4 clk = ~clk;

    spi_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide), .cfg_baud(cfg_baud),
        .cfg_sel(cfg_sel), .start(start), .tx_word(tx_word), .busy(busy),
        .done(done), .rx_word(rx_word), .sck_o(sck_o), .mosi_o(mosi_o),
        .cs_n_o(cs_n_o), .miso_i(miso_i), .sck_i(sck_i), .ss_n_i(ss_n_i),
        .mosi_i(mosi_i), .miso_o(miso_o)
    );

    always @(negedge clk) begin
        if (done) begin
            done_seen++;
            done_rx = rx_word;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] masked(input bit wide, input logic [15:0] w);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

    // Behavioural master model, compared on every cycle
    task automatic run_master(input bit cpol, input bit cpha, input bit wide,
                              input int baud, input int sel,
                              input logic [15:0] txw, input logic [15:0] resp,
                              input int inj);
        int n;
        int b;
        int len;
        n   = wide ? 16 : 8;
        b   = (baud < 2) ? 2 : baud;
        len = b * (2 * n + 1);
        @(negedge clk);
        cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
        cfg_baud = 16'(baud); cfg_sel = 3'(sel); tx_word = txw;
        miso_i = resp[n-1];
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int m = 1; m <= len + 2; m++) begin
            int e;
            int j;
            bit inw;
            logic [6:0] exp_cs;
            @(posedge clk);
            #2;
            e = m / b;
            if (e > 2 * n) e = 2 * n;
            inw = (m < len);
            exp_cs = 7'h7f;
            if (inw && sel != 0) exp_cs[sel-1] = 1'b0;
            check(cs_n_o == exp_cs, "R6 select lines", int'(cs_n_o), int'(exp_cs));
            check(busy == inw, "R9 busy window", int'(busy), int'(inw));
            check(sck_o == (inw ? (cpol ^ (e % 2 == 1)) : cpol),
                  "R1 sck timing", int'(sck_o), int'(inw ? (cpol ^ (e % 2 == 1)) : cpol));
            if (inw) begin
                if (cpha) j = (e == 0) ? 0 : (e - 1) / 2;
                else      j = e / 2;
                if (j > n - 1) j = n - 1;
                check(mosi_o == txw[n-1-j], "R4 mosi bit", int'(mosi_o), int'(txw[n-1-j]));
                miso_i = resp[n-1-j];
            end
            check(done == (m == len), "R8 done pulse", int'(done), int'(m == len));
            if (m == len)
                check(rx_word == masked(wide, resp), "R7 rx word R5",
                      int'(rx_word), int'(masked(wide, resp)));
            if (m == inj) begin
                start = 1'b1; tx_word = ~txw; cfg_baud = 16'd9; cfg_sel = 3'd1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    // Bench acts as external master; the block is the slave
    task automatic run_slave(input bit cpol, input bit cpha, input bit wide,
                             input logic [15:0] mtx, input logic [15:0] stx);
        int n;
        int s;
        int d0;
        n = wide ? 16 : 8;
        s = 0;
        @(negedge clk);
        cfg_master = 1'b0; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
        tx_word = stx; sck_i = cpol; ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        d0 = done_seen;
        ss_n_i = 1'b0;
        if (!cpha) mosi_i = mtx[n-1];
        for (int k = 0; k < 2 * n; k++) begin
            bit smp;
            repeat (8) @(negedge clk);
            smp = (k % 2 == 0) ^ cpha;
            if (smp) begin
                check(miso_o == stx[n-1-s], "R10 slave miso", int'(miso_o), int'(stx[n-1-s]));
                s++;
            end
            sck_i = ~sck_i;
            if (!smp && s < n) mosi_i = mtx[n-1-s];
        end
        repeat (8) @(negedge clk);
        check(done_seen == d0 + 1, "R10 slave done count", done_seen - d0, 1);
        check(done_rx == masked(wide, mtx), "R10 slave rx",
              int'(done_rx), int'(masked(wide, mtx)));
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(miso_o == 1'b0, "R11 miso idle", int'(miso_o), 0);
        check(busy == 1'b0, "R10 slave released", int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", int'(busy), 0);
        check(done == 1'b0, "R8 reset done", int'(done), 0);
        check(cs_n_o == 7'h7f, "R6 reset select", int'(cs_n_o), 'h7f);
        check(sck_o == 1'b0, "R3 reset sck idle", int'(sck_o), 0);
        check(miso_o == 1'b0, "R11 reset miso", int'(miso_o), 0);

        // R2: divisor 0 behaves as 2; R5 narrow word ignores upper byte
        run_master(1'b0, 1'b0, 1'b0, 0, 3, 16'hA5C3, 16'h0096, 0);
        // R2: divisor 1 behaves as 2
        run_master(1'b1, 1'b1, 1'b0, 1, 2, 16'hFF5A, 16'h003C, 0);
        // R1: divisor 3, 16-bit, phase 1
        run_master(1'b1, 1'b1, 1'b1, 3, 5, 16'hB38E, 16'h6D21, 0);
        // R6: highest select line, polarity 0 phase 1
        run_master(1'b0, 1'b1, 1'b0, 5, 7, 16'h0071, 16'h00E4, 0);
        // R9: start and setting changes mid-word ignored; R6 no select
        run_master(1'b1, 1'b0, 1'b1, 2, 0, 16'h4C1F, 16'h9AB7, 11);
        run_master(1'b0, 1'b0, 1'b1, 4, 4, 16'h8001, 16'h7FFE, 30);
        @(negedge clk);
        check(cs_n_o == 7'h7f, "R9 no restart", int'(cs_n_o), 'h7f);

        run_slave(1'b0, 1'b0, 1'b0, 16'h00C6, 16'h1259);
        run_slave(1'b1, 1'b1, 1'b1, 16'hD00B, 16'h36E9);
        run_slave(1'b0, 1'b1, 1'b1, 16'h5AA5, 16'hC381);
        run_slave(1'b1, 1'b0, 1'b0, 16'hFF33, 16'h80CC);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule